// File: doc/BRIEF.md
# Instruction-Driven Acquisition Sequencer

This block paces a self-calibrating sampling converter through a small program of up to eight instruction words. Each word describes one acquisition. It selects fine or coarse resolution, normal conversion or limit checking, an optional zero-offset or full calibration pass, and extra settling clocks. For every word the sequencer walks a fixed chain of timed states. It drives plain strobes to the converter core during that walk, and it hands a sign-extended 16-bit result to a result buffer.

The converter core is a stub. Its output `conv_data_i` is sampled on the last clock of acquisition. In limit-check mode the sample is compared against two signed thresholds and nothing is stored. A sticky limit flag then raises the interrupt. The program runs in a loop while `run_i` is high. The pointer returns to word 0 after the last word or after a word marked as the end of the sequence. When `run_i` drops, the current word finishes, and the block parks in the fetch state with the pointer at 0.

The result port is valid/ready with no buffering. `res_valid_o` is a one-clock pulse in the store state, and the data is offered only in that cycle. If `res_ready_i` is low in that cycle the buffer is taken to be full, the word is dropped and the overflow flag is set. Back-pressure never stalls the sequencer.

Top module: `acq_seq`

## Requirements
- R1: After reset: `state_o`=0, the pointer is 0, and `cal_o`, `samp_o`, `conv_o`, `res_valid_o`, `done_o`, `lim_o`, `ovf_o` and `irq_o` are all 0.
- R2: State codes are: fetch 0, decode 1, calibrate 2, store 3, second compare 4, convert 5, first compare 6, acquire 7. Fetch and decode each last 1 clock. The state order is fetch, decode, optional calibrate, acquire, then convert. In normal mode convert is followed by store for one clock, with `res_valid_o` high. The strobes are mutually exclusive: `cal_o` in calibrate, `samp_o` in acquire, `conv_o` in convert and both compares.
- R3: Convert lasts 44 clocks at full resolution and 21 clocks in low-resolution mode.
- R4: Acquire lasts 9 clocks plus the extra field, or 2 clocks plus the extra field in limit-check mode.
- R5: Calibrate runs when the auto-zero or full-cal bit is set. It lasts 76 clocks for auto-zero and 4944 clocks for full calibration; full calibration wins if both bits are set.
- R6: Limit-check mode passes through first compare (5 clocks), second compare (5 clocks) and convert (1 clock), 11 clocks in all. It produces no `res_valid_o` pulse.
- R7: In limit-check mode `lim_o` is set if the signed sample is below `lim_lo_i` or above `lim_hi_i`. The flag stays set until the next rising edge of `run_i`. `irq_o` = `done_o` OR `lim_o`.
- R8: `res_data_o` is the 13-bit sample sign-extended to 16 bits. In low-resolution mode the four low bits are cleared.
- R9: The instruction word has these fields: bit0 end-of-sequence, bit1 low resolution, bit2 limit check, bit3 auto-zero, bit4 full calibration, bits7:5 extra acquisition clocks. After a word with bit0 set, or after word 7, the pointer wraps to 0. Otherwise it increments.
- R10: A single full-resolution word with only bit0 set, repeated, produces one result every 56 clocks. A low-resolution word produces one every 33 clocks.
- R11: If `res_ready_i` is low in the store cycle, the result is dropped and `ovf_o` is set until the next rising edge of `run_i`.
- R12: A word starts only when `run_i` is high in fetch. When `run_i` is low, the current word completes, then `state_o` stays 0 and `instr_addr_o` returns to 0.
- R13: `done_o` pulses for one clock as the last word of the sequence finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request (level) |
| instr_addr_o | output | 3 | Instruction store read address |
| instr_data_i | input | 8 | Instruction word at that address |
| cal_o | output | 1 | Calibration strobe |
| samp_o | output | 1 | Acquisition (track) strobe |
| conv_o | output | 1 | Convert / compare strobe |
| conv_data_i | input | 13 | Signed sample from converter stub |
| lim_lo_i | input | 13 | Signed lower limit |
| lim_hi_i | input | 13 | Signed upper limit |
| res_valid_o | output | 1 | Result offered this cycle |
| res_ready_i | input | 1 | Result buffer can accept |
| res_data_o | output | 16 | Sign-extended result |
| state_o | output | 3 | Current state code |
| done_o | output | 1 | End-of-sequence pulse |
| lim_o | output | 1 | Sticky limit-crossed flag |
| ovf_o | output | 1 | Sticky result-overflow flag |
| irq_o | output | 1 | Interrupt |

## Verification
The bench measures how long the design stays in each state and the spacing between result pulses. An off-by-one counter load would show up at once as 55 or 57 clocks instead of 56, or 45 instead of 44. It drives negative samples and low-resolution words, which catch a missing sign extension or a failure to clear the low bits. Three programs check the pointer walk: one that ends early, one that runs all eight words, and limits crossed on either side. These expose a wrong wrap point, a result stored in limit-check mode, or a one-sided compare. Last, it holds the result buffer full and then stops the run. This catches a lost overflow flag and a sequencer that does not park with the pointer at 0.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int IW = 8;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_DECODE  = 3'd1,
    ST_CAL     = 3'd2,
    ST_STORE   = 3'd3,
    ST_CMP_HI  = 3'd4,
    ST_CONV    = 3'd5,
    ST_CMP_LO  = 3'd6,
    ST_ACQ     = 3'd7
  } seq_state_t;

  typedef struct packed {
    logic [2:0] extra;
    logic       full_cal;
    logic       auto_zero;
    logic       watch;
    logic       low_res;
    logic       last;
  } instr_t;
endpackage

// File: rtl/acq_seq_timer.sv
module acq_seq_timer #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl import acq_seq_pkg::*; #(
  parameter int DEPTH        = 8,
  parameter int CW           = 13,
  parameter int CONV_HI_CLKS = 44,
  parameter int CONV_LO_CLKS = 21,
  parameter int ACQ_STD_CLKS = 9,
  parameter int ACQ_WD_CLKS  = 2,
  parameter int ZERO_CLKS    = 76,
  parameter int CAL_CLKS     = 4944,
  parameter int CMP_LO_CLKS  = 5,
  parameter int CMP_HI_CLKS  = 5,
  parameter int CMP_END_CLKS = 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tmr_zero,
  input  instr_t        fetch_word,
  output instr_t        ins_q,
  output seq_state_t    st_q,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic [AW-1:0] ptr_q,
  output logic          done_q,
  output logic          acq_end,
  output logic          cmp_end
);
  seq_state_t st_nx;
  int         dur;
  logic       leave, seq_last;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_FETCH:  st_nx = run_i ? ST_DECODE : ST_FETCH;
      ST_DECODE: st_nx = (ins_q.auto_zero || ins_q.full_cal) ? ST_CAL : ST_ACQ;
      ST_CAL:    st_nx = ST_ACQ;
      ST_ACQ:    st_nx = ins_q.watch ? ST_CMP_LO : ST_CONV;
      ST_CMP_LO: st_nx = ST_CMP_HI;
      ST_CMP_HI: st_nx = ST_CONV;
      ST_CONV:   st_nx = ins_q.watch ? ST_FETCH : ST_STORE;
      default:   st_nx = ST_FETCH;
    endcase
  end

  always_comb begin
    case (st_nx)
      ST_CAL:    dur = ins_q.full_cal ? CAL_CLKS : ZERO_CLKS;
      ST_ACQ:    dur = (ins_q.watch ? ACQ_WD_CLKS : ACQ_STD_CLKS) + int'(ins_q.extra);
      ST_CONV:   dur = ins_q.watch ? CMP_END_CLKS
                                   : (ins_q.low_res ? CONV_LO_CLKS : CONV_HI_CLKS);
      ST_CMP_LO: dur = CMP_LO_CLKS;
      ST_CMP_HI: dur = CMP_HI_CLKS;
      default:   dur = 1;
    endcase
  end

  assign tmr_load = tmr_zero;
  assign tmr_val  = CW'(dur - 1);
  assign leave    = tmr_zero && (st_nx == ST_FETCH) && (st_q != ST_FETCH);
  assign seq_last = ins_q.last || (ptr_q == AW'(DEPTH - 1));
  assign acq_end  = (st_q == ST_ACQ) && tmr_zero;
  assign cmp_end  = (st_q == ST_CONV) && tmr_zero && ins_q.watch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      ins_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_FETCH) ins_q <= fetch_word;
      if (tmr_zero) st_q <= st_nx;
      if (st_q == ST_FETCH && !run_i) begin
        ptr_q <= '0;
      end else if (leave) begin
        ptr_q  <= seq_last ? '0 : ptr_q + AW'(1);
        done_q <= seq_last;
      end
    end
  end
endmodule

// File: rtl/acq_seq_result.sv
module acq_seq_result #(
  parameter int SW       = 13,
  parameter int DW       = 16,
  parameter int LOW_BITS = 9,
  localparam int DROP    = SW - LOW_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          acq_end,
  input  logic          cmp_end,
  input  logic          store,
  input  logic          low_res,
  input  logic [SW-1:0] conv_data_i,
  input  logic [SW-1:0] lim_lo_i,
  input  logic [SW-1:0] lim_hi_i,
  input  logic          res_ready_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_data_o,
  output logic          lim_o,
  output logic          ovf_o
);
  logic [SW-1:0] samp_q, shown;
  logic          run_q, lim_q, ovf_q, out_rng, run_rise;

  assign run_rise = run_i && !run_q;
  assign out_rng  = ($signed(samp_q) < $signed(lim_lo_i)) ||
                    ($signed(samp_q) > $signed(lim_hi_i));

  always_comb begin
    shown = samp_q;
    if (low_res) shown[DROP-1:0] = '0;
  end

  assign res_valid_o = store;
  assign res_data_o  = {{(DW - SW){shown[SW-1]}}, shown};
  assign lim_o       = lim_q;
  assign ovf_o       = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      run_q  <= 1'b0;
      lim_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      run_q <= run_i;
      if (acq_end) samp_q <= conv_data_i;
      if (run_rise) begin
        lim_q <= 1'b0;
        ovf_q <= 1'b0;
      end
      if (cmp_end && out_rng)     lim_q <= 1'b1;
      if (store && !res_ready_i)  ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq import acq_seq_pkg::*; #(
  parameter int DEPTH        = 8,
  parameter int SW           = 13,
  parameter int DW           = 16,
  parameter int LOW_BITS     = 9,
  parameter int CONV_HI_CLKS = 44,
  parameter int CONV_LO_CLKS = 21,
  parameter int ACQ_STD_CLKS = 9,
  parameter int ACQ_WD_CLKS  = 2,
  parameter int ZERO_CLKS    = 76,
  parameter int CAL_CLKS     = 4944,
  parameter int CMP_LO_CLKS  = 5,
  parameter int CMP_HI_CLKS  = 5,
  parameter int CMP_END_CLKS = 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(CAL_CLKS + 16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic [AW-1:0] instr_addr_o,
  input  logic [IW-1:0] instr_data_i,
  output logic          cal_o,
  output logic          samp_o,
  output logic          conv_o,
  input  logic [SW-1:0] conv_data_i,
  input  logic [SW-1:0] lim_lo_i,
  input  logic [SW-1:0] lim_hi_i,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic [DW-1:0] res_data_o,
  output logic [2:0]    state_o,
  output logic          done_o,
  output logic          lim_o,
  output logic          ovf_o,
  output logic          irq_o
);
  seq_state_t    st;
  instr_t        ins, fetch_w;
  logic          tmr_zero, tmr_load, acq_end, cmp_end;
  logic [CW-1:0] tmr_val;

  assign fetch_w = instr_t'(instr_data_i);

  acq_seq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  acq_seq_ctrl #(
    .DEPTH(DEPTH), .CW(CW),
    .CONV_HI_CLKS(CONV_HI_CLKS), .CONV_LO_CLKS(CONV_LO_CLKS),
    .ACQ_STD_CLKS(ACQ_STD_CLKS), .ACQ_WD_CLKS(ACQ_WD_CLKS),
    .ZERO_CLKS(ZERO_CLKS), .CAL_CLKS(CAL_CLKS),
    .CMP_LO_CLKS(CMP_LO_CLKS), .CMP_HI_CLKS(CMP_HI_CLKS), .CMP_END_CLKS(CMP_END_CLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tmr_zero(tmr_zero),
    .fetch_word(fetch_w), .ins_q(ins), .st_q(st),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .ptr_q(instr_addr_o),
    .done_q(done_o), .acq_end(acq_end), .cmp_end(cmp_end)
  );

  acq_seq_result #(.SW(SW), .DW(DW), .LOW_BITS(LOW_BITS)) u_res (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .acq_end(acq_end), .cmp_end(cmp_end), .store(st == ST_STORE),
    .low_res(ins.low_res), .conv_data_i(conv_data_i),
    .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i), .res_ready_i(res_ready_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .lim_o(lim_o), .ovf_o(ovf_o)
  );

  assign state_o = st;
  assign cal_o   = (st == ST_CAL);
  assign samp_o  = (st == ST_ACQ);
  assign conv_o  = (st == ST_CONV) || (st == ST_CMP_LO) || (st == ST_CMP_HI);
  assign irq_o   = done_o || lim_o;
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_i,
  input logic [AW-1:0] instr_addr_o,
  input logic          cal_o,
  input logic          samp_o,
  input logic          conv_o,
  input logic          res_valid_o,
  input logic [2:0]    state_o,
  input logic          lim_o,
  input logic          ovf_o
);
  // R2
  decode_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |-> ($past(state_o) == 3'd0));

  // R2
  store_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> (state_o == 3'd0));

  // R2
  conv_after_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> $past(samp_o));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_o, samp_o, conv_o, res_valid_o}));

  // R7
  lim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_o && !$rose(run_i)) |=> lim_o);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !$rose(run_i)) |=> ovf_o);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 3'd0) |-> $stable(instr_addr_o));
endmodule

bind acq_seq acq_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .instr_addr_o(instr_addr_o),
  .cal_o(cal_o), .samp_o(samp_o), .conv_o(conv_o), .res_valid_o(res_valid_o),
  .state_o(state_o), .lim_o(lim_o), .ovf_o(ovf_o)
);

// File: tb/acq_seq_tb_top.sv
module acq_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, run_i = 1'b0, res_ready_i = 1'b1;
  logic [2:0]  instr_addr_o;
  logic [7:0]  instr_data_i;
  logic [7:0]  mem [8];
  logic        cal_o, samp_o, conv_o, res_valid_o, done_o, lim_o, ovf_o, irq_o;
  logic [12:0] conv_data_i = '0, lim_lo_i = '0, lim_hi_i = '0;
  logic [15:0] res_data_o;
  logic [2:0]  state_o;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, seg = 0, prev_st = 0, vcount = 0, dcount = 0, last_v = -1, period = 0, nlog = 0;
  int seg_len [8];
  int addr_log [64];
  logic [15:0] last_data;

  always #10 clk = ~clk;
  assign instr_data_i = mem[instr_addr_o];

  acq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .instr_addr_o(instr_addr_o),
    .instr_data_i(instr_data_i), .cal_o(cal_o), .samp_o(samp_o), .conv_o(conv_o),
    .conv_data_i(conv_data_i), .lim_lo_i(lim_lo_i), .lim_hi_i(lim_hi_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_data_o(res_data_o),
    .state_o(state_o), .done_o(done_o), .lim_o(lim_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (int'(state_o) == prev_st) seg++;
    else begin seg_len[prev_st] = seg; seg = 1; prev_st = int'(state_o); end
    if (state_o == 3'd1 && seg == 1 && nlog < 64) begin addr_log[nlog] = int'(instr_addr_o); nlog++; end
    if (res_valid_o) begin
      if (last_v >= 0) period = cyc - last_v;
      last_v = cyc; vcount++; last_data = res_data_o;
    end
    if (done_o) dcount++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go(input int ncyc);
    vcount = 0; dcount = 0; last_v = -1; period = 0; nlog = 0;
    run_i = 1'b1;
    repeat (ncyc) @(negedge clk);
    run_i = 1'b0;
    do @(negedge clk); while (state_o != 3'd0);
    repeat (3) @(negedge clk);
  endtask

  function automatic int exp_data(input logic [12:0] v, input bit low);
    logic [12:0] s;
    s = v;
    if (low) s[3:0] = 4'd0;
    return int'({{3{s[12]}}, s});
  endfunction

  function automatic int exp_period(input int extra, input bit low);
    return 1 + 1 + 9 + extra + (low ? 21 : 44) + 1;
  endfunction

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int i = 0; i < 8; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(state_o), 0);
    chk("R1 strobes", int'({cal_o, samp_o, conv_o, res_valid_o}), 0);
    chk("R1 flags", int'({done_o, lim_o, ovf_o, irq_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 addr", int'(instr_addr_o), 0);

    // R2 R3 R4 R8 R10 R13 full-resolution single word, negative sample
    mem[0] = 8'h01; conv_data_i = 13'h1ED4;
    go(300);
    chk("R2 fetch len", seg_len[0], 1);
    chk("R2 decode len", seg_len[1], 1);
    chk("R2 store len", seg_len[3], 1);
    chk("R4 acq len", seg_len[7], 9);
    chk("R3 conv 44", seg_len[5], 44);
    chk("R10 period 56", period, 56);
    chk("R8 sign ext", int'(last_data), exp_data(13'h1ED4, 1'b0));
    chk("R13 done per word", dcount, vcount);
    chk("R12 parked state", int'(state_o), 0);
    chk("R12 parked addr", int'(instr_addr_o), 0);
    repeat (100) @(negedge clk);
    chk("R12 stays idle", int'(state_o), 0);

    // R3 R8 R10 low resolution
    mem[0] = 8'h03;
    go(200);
    chk("R3 conv 21", seg_len[5], 21);
    chk("R10 period 33", period, 33);
    chk("R8 low bits cleared", int'(last_data), exp_data(13'h1ED4, 1'b1));

    // R4 R8 R10 random extra clocks, resolution and samples
    for (int t = 0; t < 6; t++) begin
      int e; bit low; logic [12:0] v;
      e = int'($urandom % 8); low = 1'($urandom % 2); v = 13'($urandom);
      mem[0] = {3'(e), 4'b0000, 1'b1} | {6'd0, low, 1'b0};
      conv_data_i = v;
      go(200);
      chk("R4 acq extra", seg_len[7], 9 + e);
      chk("R10 period rnd", period, exp_period(e, low));
      chk("R8 data rnd", int'(last_data), exp_data(v, low));
    end

    // R5 calibration lengths
    mem[0] = 8'h09;
    go(150);
    chk("R5 auto-zero 76", seg_len[2], 76);
    mem[0] = 8'h19;
    go(5010);
    chk("R5 full cal wins 4944", seg_len[2], 4944);

    // R6 R7 limit check, in range
    lim_lo_i = 13'h1F9C; lim_hi_i = 13'd100; conv_data_i = 13'd50;
    mem[0] = 8'h05;
    go(60);
    chk("R6 cmp1 len", seg_len[6], 5);
    chk("R6 cmp2 len", seg_len[4], 5);
    chk("R6 cmp end len", seg_len[5], 1);
    chk("R4 acq wd 2", seg_len[7], 2);
    chk("R6 no store", vcount, 0);
    chk("R7 in range", int'(lim_o), 0);
    // R7 above upper limit
    conv_data_i = 13'd150;
    go(40);
    chk("R7 above hi", int'(lim_o), 1);
    chk("R7 irq", int'(irq_o), 1);
    // R7 cleared on run rise, then below lower limit
    conv_data_i = 13'd0;
    go(40);
    chk("R7 cleared", int'(lim_o), 0);
    conv_data_i = 13'h1F9B;
    go(40);
    chk("R7 below lo", int'(lim_o), 1);

    // R9 end bit at word 2
    mem[0] = 8'h00; mem[1] = 8'h00; mem[2] = 8'h01;
    go(340);
    chk("R9 walk a", addr_log[1], 1);
    chk("R9 walk b", addr_log[2], 2);
    chk("R9 wrap end", addr_log[3], 0);
    chk("R13 done once per pass", dcount, 2);

    // R9 no end bit: wrap after word 7
    for (int i = 0; i < 8; i++) mem[i] = 8'h00;
    go(520);
    chk("R9 word 7", addr_log[7], 7);
    chk("R9 wrap last", addr_log[8], 0);

    // R11 overflow
    mem[0] = 8'h01; res_ready_i = 1'b0;
    go(100);
    chk("R11 ovf set", int'(ovf_o), 1);
    res_ready_i = 1'b1;
    go(100);
    chk("R11 ovf cleared", int'(ovf_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule